// File: doc/BRIEF.md
# Serial port register bank

This block is the processor-facing register file of a synchronous serial port. It decodes word-aligned reads and writes inside a 4 KB address window. It holds the port's configuration: a 16-bit frame/format register, a 4-bit port-control register, an 8-bit clock prescaler and a 4-bit interrupt enable mask. It also owns the data port, which pushes words into the transmit FIFO and pops words from the receive FIFO. The FIFOs and the shifting engine live in a neighbouring block, which reports its two occupancy counts and the word at the receive head.

Status flags and the raw, masked and combined interrupt outputs are all derived from the two occupancy counts, with the FIFO interrupts tied to a half-depth threshold. The two error interrupt sources, receive overrun and receive timeout, are never raised by this block, so their clear-register bits have nothing to act on. The DMA control word is accepted and discarded. A fixed table of eight identification bytes occupies the top 32 bytes of the window.

The bus is a single-cycle handshake. Read data is combinational in the cycle where `bus_valid` is high and `bus_write` is low. Writes take effect at the clock edge that ends that cycle.

Top module: `ssp_csr_bank`

## Requirements
- R1: After reset, the frame register (0x00), control register (0x04), prescaler (0x10) and mask (0x14) read 0. With both counts zero, status (0x0C) reads 0x03, raw interrupt (0x18) reads 0x08 and masked interrupt (0x1C) reads 0.
- R2: Writes update the stored registers, and reads return them:
  - The frame register keeps all 16 bits.
  - The control register keeps bits 3:0.
  - The prescaler keeps bits 7:0.
  - The mask keeps bits 3:0.
  - `ctrl0_out`, `ctrl1_out` and `prescale_out` always show the stored values.
  - Each stored value changes only on a write to its own offset.
- R3: The status word at 0x0C is defined bit by bit as follows:
  - Bit 0 is set when the TX count is 0.
  - Bit 1 is set when the TX count differs from the depth.
  - Bit 2 is set when the RX count is nonzero.
  - Bit 3 is set when the RX count equals the depth.
  - Bit 4 is set when the TX count is nonzero.
  - The upper bits read 0.
- R4: The raw interrupt word at 0x18 has bit 2 set when the RX count is at least half the depth (4). Bit 3 is set when the TX count is at most half the depth. Bits 1:0 and the upper bits read 0.
- R5: The masked interrupt word at 0x1C equals the raw word ANDed with the mask. `irq` is high exactly when that AND is nonzero.
- R6: A write to the clear register at 0x20 leaves the RX (bit 2) and TX (bit 3) raw bits unchanged. Bits 1:0 stay 0.
- R7: A write to 0x08 while the TX count is below the depth pulses `tx_push` for that cycle. `tx_data` carries the written value masked to its low N+1 bits, where N is frame register bits 3:0. When the TX FIFO is full, the write is discarded and there is no push.
- R8: A read of 0x08 with a nonzero RX count returns `rx_head` and pulses `rx_pop` in the same cycle. With an RX count of 0, the read returns 0 and does not pop.
- R9: Reads at 0xFE0 + 4k, for k from 0 to 7, return the byte sequence 0x22, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in order of k.
- R10: The following return 0 on a read and change no stored register on a write:
  - the DMA control offset 0x24;
  - every offset without a register or ID byte;
  - every offset whose low two bits are nonzero.
- R11: `tx_push` and `rx_pop` are low in every cycle that is not, respectively, a valid write or a valid read of offset 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the window |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the access cycle |
| tx_count | input | CNT_W | TX FIFO occupancy, 0 to DEPTH |
| rx_count | input | CNT_W | RX FIFO occupancy, 0 to DEPTH |
| rx_head | input | BUS_W | Oldest RX FIFO entry |
| tx_push | output | 1 | Push strobe to the TX FIFO |
| tx_data | output | BUS_W | Masked word to push |
| rx_pop | output | 1 | Pop strobe to the RX FIFO |
| ctrl0_out | output | BUS_W | Stored frame/format register |
| ctrl1_out | output | 4 | Stored port-control register |
| prescale_out | output | 8 | Stored clock prescaler |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that the FIFO block keeps both occupancy counts within 0 to DEPTH, that each count is stable within a cycle, and that accesses carry a well-defined address whenever `bus_valid` is high. The stimulus drives every count from an integer held within that range. It changes the inputs only just after a rising edge. It steers the address across mapped registers, the ID table, unmapped holes and misaligned offsets. The counts sweep the empty, half, full and one-off-threshold points of both FIFOs under several masks, so that each status and interrupt bit is seen both set and clear.

// File: rtl/ssp_csr_pkg.sv
`timescale 1ns/1ps
package ssp_csr_pkg;

  // Word indices inside the window (byte offset / 4)
  localparam int WI_FRAME   = 0;
  localparam int WI_CTRL    = 1;
  localparam int WI_DATA    = 2;
  localparam int WI_STATUS  = 3;
  localparam int WI_PRESC   = 4;
  localparam int WI_MASK    = 5;
  localparam int WI_RAW     = 6;
  localparam int WI_MASKED  = 7;
  localparam int WI_CLEAR   = 8;
  localparam int WI_DMA     = 9;

  localparam int STAT_W  = 5;
  localparam int IRQ_W   = 4;
  localparam int CTRL_W  = 4;
  localparam int PRESC_W = 8;
  localparam int IDB_W   = 8;

  // Interrupt bit positions (neighbours decode these)
  localparam int IRQB_RX = 2;
  localparam int IRQB_TX = 3;

  typedef struct packed {
    logic id;
    logic dma;
    logic clr;
    logic masked;
    logic raw;
    logic mask;
    logic presc;
    logic status;
    logic data;
    logic ctrl;
    logic frame;
  } csr_sel_t;

  function automatic logic [IDB_W-1:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    id_byte = 8'h22;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h04;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/ssp_csr_decode.sv
`timescale 1ns/1ps
module ssp_csr_decode
  import ssp_csr_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output csr_sel_t          sel,
  output logic [2:0]        id_idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              in_id;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);
  assign in_id   = (addr[ADDR_W-1:5] == '1);
  assign id_idx  = addr[4:2];

  function automatic logic hit(input logic [WORD_W-1:0] w, input int idx, input logic al);
    hit = al && (w == WORD_W'(idx));
  endfunction

  always_comb begin
    sel        = '0;
    sel.frame  = hit(word, WI_FRAME,  aligned);
    sel.ctrl   = hit(word, WI_CTRL,   aligned);
    sel.data   = hit(word, WI_DATA,   aligned);
    sel.status = hit(word, WI_STATUS, aligned);
    sel.presc  = hit(word, WI_PRESC,  aligned);
    sel.mask   = hit(word, WI_MASK,   aligned);
    sel.raw    = hit(word, WI_RAW,    aligned);
    sel.masked = hit(word, WI_MASKED, aligned);
    sel.clr    = hit(word, WI_CLEAR,  aligned);
    sel.dma    = hit(word, WI_DMA,    aligned);
    sel.id     = aligned && in_id;
  end

endmodule

// File: rtl/ssp_csr_flags.sv
`timescale 1ns/1ps
module ssp_csr_flags
  import ssp_csr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic [CNT_W-1:0]  tx_count,
  input  logic [CNT_W-1:0]  rx_count,
  input  logic [IRQ_W-1:0]  imask,
  output logic [STAT_W-1:0] status,
  output logic [IRQ_W-1:0]  raw,
  output logic [IRQ_W-1:0]  masked,
  output logic              irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

  function automatic logic at_least(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    at_least = (c >= t);
  endfunction

  function automatic logic at_most(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    at_most = (c <= t);
  endfunction

  always_comb begin
    status    = '0;
    status[0] = (tx_count == '0);
    status[1] = (tx_count != FULL_CNT);
    status[2] = (rx_count != '0);
    status[3] = (rx_count == FULL_CNT);
    status[4] = (tx_count != '0);
  end

  always_comb begin
    raw          = '0;
    raw[IRQB_RX] = at_least(rx_count, HALF_CNT);
    raw[IRQB_TX] = at_most(tx_count, HALF_CNT);
  end

  assign masked = raw & imask;
  assign irq    = |masked;

endmodule

// File: rtl/ssp_csr_bank.sv
`timescale 1ns/1ps
module ssp_csr_bank
  import ssp_csr_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic [CNT_W-1:0]   rx_count,
  input  logic [BUS_W-1:0]   rx_head,
  output logic               tx_push,
  output logic [BUS_W-1:0]   tx_data,
  output logic               rx_pop,
  output logic [BUS_W-1:0]   ctrl0_out,
  output logic [CTRL_W-1:0]  ctrl1_out,
  output logic [PRESC_W-1:0] prescale_out,
  output logic               irq
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  csr_sel_t           sel;
  logic [2:0]         id_idx;
  logic               wr_en, rd_en;
  logic [BUS_W-1:0]   frame_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [PRESC_W-1:0] presc_q;
  logic [IRQ_W-1:0]   mask_q;
  logic [STAT_W-1:0]  status;
  logic [IRQ_W-1:0]   raw, masked;

  // Named events for the checker
  logic ev_data_wr, ev_data_rd, ev_clear_wr;

  ssp_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .sel    (sel),
    .id_idx (id_idx)
  );

  ssp_csr_flags #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_flags (
    .tx_count (tx_count),
    .rx_count (rx_count),
    .imask    (mask_q),
    .status   (status),
    .raw      (raw),
    .masked   (masked),
    .irq      (irq)
  );

  assign wr_en       = bus_valid && bus_write;
  assign rd_en       = bus_valid && !bus_write;
  assign ev_data_wr  = wr_en && sel.data;
  assign ev_data_rd  = rd_en && sel.data;
  assign ev_clear_wr = wr_en && sel.clr;

  // Frame size field selects how many low bits of a pushed word survive
  function automatic logic [BUS_W-1:0] size_mask(input logic [3:0] sz);
    logic [BUS_W-1:0] m;
    for (int i = 0; i < BUS_W; i++) m[i] = (i <= int'(sz));
    return m;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      ctrl_q  <= '0;
      presc_q <= '0;
      mask_q  <= '0;
    end else if (wr_en) begin
      if (sel.frame) frame_q <= bus_wdata;
      if (sel.ctrl)  ctrl_q  <= bus_wdata[CTRL_W-1:0];
      if (sel.presc) presc_q <= bus_wdata[PRESC_W-1:0];
      if (sel.mask)  mask_q  <= bus_wdata[IRQ_W-1:0];
    end
  end

  assign tx_push = ev_data_wr && (tx_count != FULL_CNT);
  assign tx_data = bus_wdata & size_mask(frame_q[3:0]);
  assign rx_pop  = ev_data_rd && (rx_count != '0);

  always_comb begin
    bus_rdata = '0;
    if (sel.frame)                bus_rdata = frame_q;
    else if (sel.ctrl)            bus_rdata = BUS_W'(ctrl_q);
    else if (sel.data)            bus_rdata = (rx_count != '0) ? rx_head : '0;
    else if (sel.status)          bus_rdata = BUS_W'(status);
    else if (sel.presc)           bus_rdata = BUS_W'(presc_q);
    else if (sel.mask)            bus_rdata = BUS_W'(mask_q);
    else if (sel.raw)             bus_rdata = BUS_W'(raw);
    else if (sel.masked)          bus_rdata = BUS_W'(masked);
    else if (sel.clr || sel.dma)  bus_rdata = '0;
    else if (sel.id)              bus_rdata = BUS_W'(id_byte(id_idx));
  end

  assign ctrl0_out    = frame_q;
  assign ctrl1_out    = ctrl_q;
  assign prescale_out = presc_q;

endmodule

// File: rtl/ssp_csr_checker.sv
`timescale 1ns/1ps
module ssp_csr_checker #(
  parameter int ADDR_W = 12,
  parameter int BUS_W  = 16,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic [CNT_W-1:0]  tx_count,
  input logic [CNT_W-1:0]  rx_count,
  input logic              tx_push,
  input logic              rx_pop,
  input logic              irq,
  input logic [3:0]        imask,
  input logic [7:0]        presc,
  input logic              ev_clear_wr
);
  localparam logic [CNT_W-1:0]  FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0]  HALF = CNT_W'(DEPTH / 2);
  localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_PRESC = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] A_RAW   = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] A_ID    = ADDR_W'(12'hFE0);

  AST_PUSH_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> tx_count != FULL); // R7
  AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> rx_count != '0); // R8
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr == A_DATA && rx_count == '0) |-> bus_rdata == '0); // R8
  AST_PUSH_ONLY_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
    tx_push |-> (bus_valid && bus_write && bus_addr == A_DATA)); // R11
  AST_POP_ONLY_DATA_RD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> (bus_valid && !bus_write && bus_addr == A_DATA)); // R11
  AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((imask[3] && tx_count <= HALF) || (imask[2] && rx_count >= HALF))); // R5
  AST_IRQ_TX_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (imask[3] && tx_count <= HALF) |-> irq); // R5
  AST_IRQ_RX_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (imask[2] && rx_count >= HALF) |-> irq); // R5
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == A_MASK) |=> $stable(imask)); // R2
  AST_PRESC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_addr == A_PRESC) |=> $stable(presc)); // R2
  AST_CLEAR_KEEPS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clear_wr && $stable(tx_count) && $stable(rx_count)) |=>
      (!(bus_valid && !bus_write && bus_addr == A_RAW) || bus_rdata[1:0] == 2'b00)); // R6
  AST_ID_IS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && bus_addr >= A_ID) |-> bus_rdata[BUS_W-1:8] == '0); // R9

endmodule

bind ssp_csr_bank ssp_csr_checker #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_valid   (bus_valid),
  .bus_write   (bus_write),
  .bus_addr    (bus_addr),
  .bus_rdata   (bus_rdata),
  .tx_count    (tx_count),
  .rx_count    (rx_count),
  .tx_push     (tx_push),
  .rx_pop      (rx_pop),
  .irq         (irq),
  .imask       (mask_q),
  .presc       (presc_q),
  .ev_clear_wr (ev_clear_wr)
);

// File: tb/sim_ssp_csr_bank.sv
`timescale 1ns/1ps
module sim_ssp_csr_bank;
  localparam int ADDR_W = 12;
  localparam int BUS_W  = 16;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [BUS_W-1:0]  bus_wdata = '0, bus_rdata, rx_head = '0, tx_data, ctrl0_out;
  logic [CNT_W-1:0]  tx_count = '0, rx_count = '0;
  logic tx_push, rx_pop, irq;
  logic [3:0] ctrl1_out;
  logic [7:0] prescale_out;

  always #2.5 clk = ~clk;

  ssp_csr_bank #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DEPTH(DEPTH)) u0 (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_addr, .bus_wdata, .bus_rdata,
    .tx_count, .rx_count, .rx_head, .tx_push, .tx_data, .rx_pop,
    .ctrl0_out, .ctrl1_out, .prescale_out, .irq
  );

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  // Model state
  int m_frame = 0, m_ctrl = 0, m_presc = 0, m_mask = 0;
  int id_tab[8] = '{'h22, 'h10, 'h04, 'h00, 'h0D, 'hF0, 'h05, 'hB1};

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int m_raw(input int tc, input int rc);
    int r = 0;
    if (rc >= DEPTH / 2) r += 4;
    if (tc <= DEPTH / 2) r += 8;
    return r;
  endfunction

  function automatic int m_status(input int tc, input int rc);
    int s = 0;
    if (tc == 0)     s += 1;
    if (tc < DEPTH)  s += 2;
    if (rc > 0)      s += 4;
    if (rc == DEPTH) s += 8;
    if (tc > 0)      s += 16;
    return s;
  endfunction

  function automatic int m_read(input int a, input int tc, input int rc, input int rh);
    if (a % 4 != 0) return 0;
    if (a >= 'hFE0 && a <= 'hFFC) return id_tab[(a - 'hFE0) / 4];
    case (a)
      'h00: return m_frame;
      'h04: return m_ctrl;
      'h08: return (rc > 0) ? rh : 0;
      'h0C: return m_status(tc, rc);
      'h10: return m_presc;
      'h14: return m_mask;
      'h18: return m_raw(tc, rc);
      'h1C: return m_raw(tc, rc) & m_mask;
      default: return 0;
    endcase
  endfunction

  // One bus cycle: drive after the rising edge, compare mid-cycle, advance model
  task automatic cyc(input bit v, input bit w, input int a, input int d,
                     input int tc, input int rc, input int rh, input string tag);
    int exp_push, exp_pop;
    @(posedge clk); #1;
    bus_valid = v; bus_write = w; bus_addr = ADDR_W'(a); bus_wdata = BUS_W'(d);
    tx_count = CNT_W'(tc); rx_count = CNT_W'(rc); rx_head = BUS_W'(rh);
    @(negedge clk);
    exp_push = (v && w && a == 8 && tc < DEPTH) ? 1 : 0;
    exp_pop  = (v && !w && a == 8 && rc > 0) ? 1 : 0;
    chk("R5", "irq", int'(irq), ((m_raw(tc, rc) & m_mask) != 0) ? 1 : 0);
    chk((v && w && a == 8) ? "R7" : "R11", "tx_push", int'(tx_push), exp_push);
    chk((v && !w && a == 8) ? "R8" : "R11", "rx_pop", int'(rx_pop), exp_pop);
    chk("R2", "ctrl0_out", int'(ctrl0_out), m_frame);
    chk("R2", "ctrl1_out", int'(ctrl1_out), m_ctrl);
    chk("R2", "prescale_out", int'(prescale_out), m_presc);
    if (exp_push == 1)
      chk("R7", "tx_data", int'(tx_data), d % (1 << ((m_frame % 16) + 1)));
    if (v && !w)
      chk(tag, $sformatf("rdata@%0h", a), int'(bus_rdata), m_read(a, tc, rc, rh));
    if (v && w) begin
      case (a)
        'h00: m_frame = d % 65536;
        'h04: m_ctrl  = d % 16;
        'h10: m_presc = d % 256;
        'h14: m_mask  = d % 16;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input int a, input int tc, input int rc, input int rh, input string tag);
    cyc(1, 0, a, 0, tc, rc, rh, tag);
  endtask

  task automatic wr(input int a, input int d, input int tc, input int rc, input string tag);
    cyc(1, 1, a, d, tc, rc, 0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int tcs[6] = '{0, 1, 4, 5, 7, 8};
    int rcs[5] = '{0, 3, 4, 7, 8};
    int masks[4] = '{8, 4, 3, 15};
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd('h00, 0, 0, 0, "R1"); rd('h04, 0, 0, 0, "R1"); rd('h10, 0, 0, 0, "R1");
    rd('h14, 0, 0, 0, "R1"); rd('h0C, 0, 0, 0, "R1"); rd('h18, 0, 0, 0, "R1");
    rd('h1C, 0, 0, 0, "R1");

    // R2 write and read back, field widths
    wr('h00, 'hBEEF, 0, 0, "R2"); rd('h00, 0, 0, 0, "R2");
    wr('h04, 'h3A, 0, 0, "R2");   rd('h04, 0, 0, 0, "R2");
    wr('h10, 'h1234, 0, 0, "R2"); rd('h10, 0, 0, 0, "R2");
    wr('h14, 'h3C, 0, 0, "R2");   rd('h14, 0, 0, 0, "R2");

    // R3 R4 R5 over count grid and masks
    foreach (masks[mi]) begin
      wr('h14, masks[mi], 0, 0, "R5");
      foreach (tcs[ti]) foreach (rcs[ri]) begin
        rd('h0C, tcs[ti], rcs[ri], 0, "R3");
        rd('h18, tcs[ti], rcs[ri], 0, "R4");
        rd('h1C, tcs[ti], rcs[ri], 0, "R5");
      end
    end

    // R6 clear register leaves RX/TX bits alone
    wr('h20, 'hF, 2, 6, "R6"); rd('h18, 2, 6, 0, "R6");
    wr('h20, 'hF, 6, 1, "R6"); rd('h18, 6, 1, 0, "R6");

    // R7 pushes with several frame sizes, full FIFO discard
    wr('h00, 'h0007, 0, 0, "R7");
    wr('h08, 'hABCD, 0, 0, "R7"); wr('h08, 'hABCD, 3, 0, "R7"); wr('h08, 'hABCD, 7, 0, "R7");
    wr('h08, 'hABCD, 8, 0, "R7");
    wr('h00, 'h000F, 0, 0, "R7"); wr('h08, 'hABCD, 1, 0, "R7");
    wr('h00, 'h0003, 0, 0, "R7"); wr('h08, 'hABCD, 1, 0, "R7");
    wr('h00, 'h0000, 0, 0, "R7"); wr('h08, 'hFFFF, 5, 0, "R7");

    // R8 data reads
    rd('h08, 0, 2, 'h55AA, "R8"); rd('h08, 0, 8, 'h1234, "R8"); rd('h08, 0, 0, 'h7777, "R8");

    // R9 identification bytes
    for (int k = 0; k < 8; k++) rd('hFE0 + 4 * k, 0, 0, 0, "R9");

    // R10 DMA, holes, misaligned
    rd('h24, 0, 0, 0, "R10"); rd('h28, 0, 0, 0, "R10"); rd('h100, 0, 0, 0, "R10");
    rd('hFDC, 0, 0, 0, "R10"); rd('h002, 0, 0, 0, "R10"); rd('h00A, 0, 3, 'h4321, "R10");
    wr('h24, 'hFFFF, 0, 0, "R10"); wr('h30, 'hFFFF, 0, 0, "R10");
    wr('h006, 'hFFFF, 0, 0, "R10"); wr('h012, 'hFFFF, 0, 0, "R10");
    rd('h00, 0, 0, 0, "R10"); rd('h04, 0, 0, 0, "R10");
    rd('h10, 0, 0, 0, "R10"); rd('h14, 0, 0, 0, "R10");

    // R11 idle and unrelated accesses never push or pop
    cyc(0, 0, 'h08, 'h1111, 2, 5, 'h99, "R11");
    cyc(0, 1, 'h08, 'h1111, 2, 5, 'h99, "R11");
    rd('h0C, 2, 5, 'h99, "R11"); wr('h0C, 'h1, 2, 5, "R11");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule